// File: doc/BRIEF.md
# Shift-and-Add Sequential Multiplier

This block forms the unsigned product of two `W`-bit operands over several clock cycles, using one `2W`-bit adder and two shift registers instead of a full combinational array. The multiplicand is zero-extended into a `2W`-bit register that moves one place left per cycle. The multiplier sits in a `W`-bit register that moves one place right per cycle. Whenever the multiplier's low bit is 1, the current multiplicand is added into the product register. The run stops as soon as the multiplier register holds zero, so small multipliers finish early.

A user holds `start` low and presents the operands. While `start` is low the block captures them on every edge and keeps `product` at zero. Raising `start` launches the run with the operands captured on the last low-`start` edge. `done` then rises and stays high, with the product frozen, until `start` is lowered. The controller has three states:

- `ST_IDLE` captures the operands and clears the product. Transition *launch*: `start`=1 moves it to `ST_RUN`.
- `ST_RUN` shifts both operands and conditionally accumulates. Transition *finish*: the multiplier register being zero moves it to `ST_DONE`.
- `ST_DONE` asserts `done`. Transition *release*: `start`=0 moves it to `ST_IDLE`.

Reset enters `ST_IDLE`.

Top module: `seq_shift_mult`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: In `ST_IDLE`, every edge with `start`=0 captures `opnd_a` and `opnd_b` and clears `product` to 0.
- R3: An edge with `start`=1 in `ST_IDLE` moves to `ST_RUN` without capturing operands, so the run uses the values from the last edge where `start` was 0.
- R4: When `done` is 1, `product` equals the unsigned product of the captured operands as a `2W`-bit value. Example: 13 × 11 = 143.
- R5: In each `ST_RUN` cycle, the shifted multiplicand is added to `product` only when the multiplier register's bit 0 is 1. After the first run edge, `product` equals A when B[0]=1 and 0 when B[0]=0. Both shifts insert 0 at the vacated end.
- R6: `done` rises exactly k+1 edges after the launch edge, where k is the bit length of B (the index of its highest 1, plus one). B=0 gives one edge.
- R7: While `done` is 1 and `start` stays 1, `done` stays 1 and `product` is stable. Operand inputs have no effect outside edges in `ST_IDLE` with `start`=0.
- R8: In `ST_DONE`, an edge with `start`=0 returns to `ST_IDLE` and drops `done`. `product` reads 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request; also hold/release handshake in done |
| opnd_a | input | W | Multiplicand |
| opnd_b | input | W | Multiplier |
| product | output | 2W | Accumulated product |
| done | output | 1 | Result valid |

## Verification
A wrong controller state appears at the ports at once. A missed *finish* leaves `done` low past the k+1-edge window. A missed *release* keeps `done` high after `start` falls. A stray operand capture during a run changes `product` by the final edge. A wrong accumulate decision is visible on `product` one edge after the run starts, because the first-cycle value must be either A or 0. A wrong shift or adder width shows up as a wrong final product, most clearly for all-ones operands where the top product bits are used.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } smul_state_t;

    // control bundle from controller to datapath
    typedef struct packed {
        logic p_sel;     // 0: clear value, 1: adder sum
        logic p_en;      // product register enable
        logic ab_load;   // capture operands
        logic ab_shift;  // shift operands
    } smul_ctl_t;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      b_zero,
    input  logic      b_lsb,
    output smul_ctl_t ctl,
    output logic      done
);

    smul_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)  state_d = ST_RUN;
            ST_RUN:  if (b_zero) state_d = ST_DONE;
            ST_DONE: if (!start) state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl  = '0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctl.p_sel   = 1'b0;
                ctl.p_en    = 1'b1;
                ctl.ab_load = !start;
            end
            ST_RUN: begin
                ctl.p_sel    = 1'b1;
                ctl.ab_shift = 1'b1;
                ctl.p_en     = b_lsb && !b_zero;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: launch goes straight to the run state
    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_RUN));

    // R7: holding start keeps the result state
    assert_hold_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && start) |=> (state_q == ST_DONE));

    // R8: release returns to idle
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !start) |=> (state_q == ST_IDLE));

    // only the three encoded states are ever reached
    assert_legal_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);

endmodule

// File: rtl/smul_opnd_shifter.sv
module smul_opnd_shifter #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           shift,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [2*W-1:0] a_val,
    output logic           b_lsb,
    output logic           b_zero
);

    localparam int AW = 2 * W;

    logic [AW-1:0] a_q;
    logic [W-1:0]  b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= {{W{1'b0}}, opnd_a};
            b_q <= opnd_b;
        end else if (shift) begin
            a_q <= {a_q[AW-2:0], 1'b0};
            b_q <= {1'b0, b_q[W-1:1]};
        end
    end

    assign a_val  = a_q;
    assign b_lsb  = b_q[0];
    assign b_zero = (b_q == '0);

    // R5: the multiplier loses one bit per shift and never gains one
    assert_b_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (b_q <= $past(b_q)));

    // R7: no capture or shift leaves operands untouched
    assert_opnd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !load) |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           p_sel,
    input  logic           p_en,
    input  logic [2*W-1:0] addend,
    output logic [2*W-1:0] product
);

    localparam int PW = 2 * W;

    logic [PW-1:0] p_q;
    logic [PW-1:0] sum;
    logic [PW-1:0] p_next;

    assign sum    = p_q + addend;
    assign p_next = p_sel ? sum : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    p_q <= '0;
        else if (p_en) p_q <= p_next;
    end

    assign product = p_q;

    // R4: accumulation never wraps past 2W bits
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_sel && p_en) |=> (p_q >= $past(p_q)));

endmodule

// File: rtl/seq_shift_mult.sv
module seq_shift_mult
    import smul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [2*W-1:0] product,
    output logic           done
);

    localparam int PW = 2 * W;

    smul_ctl_t     ctl;
    logic [PW-1:0] a_val;
    logic          b_lsb;
    logic          b_zero;

    smul_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .b_zero (b_zero),
        .b_lsb  (b_lsb),
        .ctl    (ctl),
        .done   (done)
    );

    smul_opnd_shifter #(.W(W)) u_opnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctl.ab_load),
        .shift  (ctl.ab_shift),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .a_val  (a_val),
        .b_lsb  (b_lsb),
        .b_zero (b_zero)
    );

    smul_accum #(.W(W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .p_sel   (ctl.p_sel),
        .p_en    (ctl.p_en),
        .addend  (a_val),
        .product (product)
    );

    // R6: the result state is only reached with the multiplier exhausted
    assert_done_b_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> b_zero);

    // R7: product frozen while the result is held
    assert_hold_product_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> $stable(product));

    // R2: idle with start low gives a zero product next edge
    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !ctl.p_sel && ctl.p_en && !start) |=> (product == '0));

endmodule

// File: tb/sim_seq_shift_mult.sv
`timescale 1ns/1ps
module sim_seq_shift_mult;

    localparam int W  = 8;
    localparam int PW = 2 * W;
    localparam int NV = 10;

    // {a, b, expected product}
    localparam logic [31:0] VEC [NV] = '{
        {8'h0D, 8'h0B, 16'h008F},
        {8'hFF, 8'hFF, 16'hFE01},
        {8'h00, 8'h5A, 16'h0000},
        {8'h5A, 8'h00, 16'h0000},
        {8'h01, 8'h80, 16'h0080},
        {8'h80, 8'h01, 16'h0080},
        {8'hA5, 8'h3C, 16'h26AC},
        {8'hFF, 8'h01, 16'h00FF},
        {8'h01, 8'hFF, 16'h00FF},
        {8'h12, 8'h34, 16'h03A8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  opnd_a = '0;
    logic [W-1:0]  opnd_b = '0;
    logic [PW-1:0] product;
    logic          done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    seq_shift_mult #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .product(product), .done(done)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bitlen(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    // one full transaction; launch_a/launch_b are driven on the launch edge
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [PW-1:0] exp_p,
                           input logic [W-1:0] launch_a, input logic [W-1:0] launch_b);
        int cycles;
        @(negedge clk);
        opnd_a = a; opnd_b = b; start = 1'b0;
        @(posedge clk); #1;
        chk(product == '0, "R2 idle clear", 32'(product), 0);
        @(negedge clk);
        start = 1'b1; opnd_a = launch_a; opnd_b = launch_b;
        @(posedge clk); #1;
        opnd_a = ~a; opnd_b = ~b;   // must be ignored during the run
        cycles = 0;
        while (!done && cycles < 4 * W) begin
            @(posedge clk); #1;
            cycles++;
            if (cycles == 1)
                chk(product == (b[0] ? PW'(a) : '0), "R5 first step",
                    32'(product), 32'(b[0] ? PW'(a) : '0));
        end
        chk(cycles == bitlen(b) + 1, "R6 latency", cycles, bitlen(b) + 1);
        chk(product == exp_p, "R4 product", 32'(product), 32'(exp_p));
        repeat (3) @(posedge clk);
        #1;
        chk(done && product == exp_p, "R7 hold", 32'(product), 32'(exp_p));
        @(negedge clk); start = 1'b0;
        @(posedge clk); #1;
        chk(!done, "R8 done drop", 32'(done), 0);
        @(posedge clk); #1;
        chk(product == '0, "R8 product clear", 32'(product), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!done && product == '0, "R1 reset", 32'(product), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!done && product == '0, "R1 after release", 32'(product), 0);

        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] va = VEC[i][31:24];
            logic [W-1:0] vb = VEC[i][23:16];
            logic [PW-1:0] vp = VEC[i][15:0];
            run_mul(va, vb, vp, va, vb);
        end

        // R3: operands present on the launch edge are not captured
        run_mul(8'd3, 8'd5, 16'd15, 8'd7, 8'd9);
        run_mul(8'd200, 8'd0, 16'd0, 8'd255, 8'd255);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule